// File: doc/BRIEF.md
# Three-Wire Tap Stepping Sequencer

This block is the host-side driver for a 32-position digital potentiometer whose wiper is moved by three control lines: an active-low select, an active-low step line whose falling edge moves the wiper by one position, and a direction line. Software or another block hands it a command on a valid/ready handshake. Each command holds a destination position and a flag that says whether the new position should be written to the part's non-volatile memory when the part is released. A separate flag asks for a homing run instead.

The sequencer keeps its own copy of the wiper position. From that copy it works out the direction and the number of step pulses, then plays the pulses out while honouring every minimum setup, hold, pulse-width and period time. Each of those times is a parameter in nanoseconds, converted to clock cycles from a clock-frequency parameter. The release of the select line is sequenced in one of two ways. For a store, the step line is high when select rises, and a long recovery follows. For a discard, the step line is held low while select rises, and a short recovery follows. The next command is held off until the recovery has elapsed, and a one-cycle done pulse marks the end of each command.

Top module: `tapseq_sequencer`

## Requirements
- R1: Reset state. While reset is applied and in the first cycle after it, select and step are high, ready is high, done is low and the tracked position is 0.
- R2: Moves and counting. A command moves the wiper toward its destination with exactly |destination − tracked position| falling edges on step, all made while select is low. The direction line is 1 for upward moves and 0 for downward moves. The tracked position changes only in the cycle in which step falls, and it equals the destination when done rises.
- R3: Setup before a step edge. Select must have been low for at least T_SEL_SETUP, and direction unchanged for at least T_DIR_SETUP, before every falling edge of step.
- R4: Step pulse timing. Step stays low for at least T_STEP_LOW and high for at least T_STEP_HIGH between edges, and successive falling edges are at least T_STEP_PERIOD apart.
- R5: Direction hold. The direction line changes only while step is high, and only after step has been high for at least T_DIR_HOLD.
- R6: Step settle before release. Step is unchanged for at least T_STEP_SETTLE before select rises.
- R7: Store release. With the store flag set, select rises while step is high, and select then stays high for at least T_STORE_REC before the next selection.
- R8: Discard release. With the store flag clear and at least one move, the last step falling edge is held low while select rises. Select stays high for at least T_DISCARD_REC, and only after that does step return high.
- R9: No-move commands. A command whose destination equals the tracked position makes no step edges. With the store flag set, it still selects the part and releases it with a store. With the flag clear, it leaves select, step and direction untouched.
- R10: Homing. A homing command makes 31 downward step edges whatever the tracked position is. Both the tracked position and a physical wiper starting anywhere end at 0, since neither moves below 0.
- R11: Handshake. Ready falls in the cycle after a command is accepted and stays low until the release recovery has elapsed. Done is high for exactly one cycle, the first cycle in which ready is high again.
- R12: Time conversion. Each time minimum in ns becomes ceil(ns × CLK_HZ / 10^9) clock cycles, and never fewer than 1. With a 1 MHz clock, the 2900 ns direction setup becomes 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken when high together with cmd_valid |
| cmd_target | input | 5 | Destination tap position (0..31) |
| cmd_store | input | 1 | 1: write the final position to non-volatile memory on release |
| cmd_init | input | 1 | 1: homing run to position 0; cmd_target is ignored |
| done | output | 1 | One-cycle completion pulse |
| sel_n | output | 1 | Active-low device select line |
| step_n | output | 1 | Step line; each falling edge while selected moves the wiper |
| dir_up | output | 1 | Direction line, 1 = upward |
| pos_out | output | 5 | Tracked wiper position |

## Verification
A wrong step count or a bad tracked position shows up at the end of the same command. The step edges are counted against a behavioural wiper model, and that model, pos_out and any stored value disagree as soon as done rises. A wrong timer load or a wrong choice of state on release shows up at the very edge concerned. The bench measures, cycle by cycle, how long each line has held its level when another line moves, so a setup, hold, pulse-width or recovery time that is one cycle short is reported at that edge, and a wrong step level at the select rise is reported as a missing or extra store. Sweeping every source and destination pair covers both end positions and both directions, and shows at once any off-by-one in the pulse count or in the clamping.

// File: rtl/tapseq_pkg.sv
// Shared types and helpers for the tap stepping sequencer.
// Assumes time values in ns and clock rates in Hz fit in 64-bit arithmetic.
package tapseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a command, part deselected
        ST_SETUP,  // part selected, direction settling before the first edge
        ST_LOW,    // step line low (one move made at entry)
        ST_HIGH,   // step line high between moves
        ST_FINAL,  // step high settle before a storing release
        ST_DESEL,  // select released, store or discard recovery
        ST_RECOV   // step returned high after a discard, direction hold
    } seq_state_t;

    // Converts a minimum time in ns to whole clock cycles, rounding up, at least one.
    function automatic int unsigned cycles_for(input longint unsigned ns,
                                               input longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 64'd0) c = 64'd1;
        return 32'(c);
    endfunction

    // Larger of two cycle counts.
    function automatic int unsigned larger(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tapseq_timer.sv
// Down-counting interval timer.
// A load of N-1 makes 'zero' true in the N-th cycle after the load edge, so a
// state that loads on entry and leaves on 'zero' lasts exactly N cycles.
module tapseq_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);

    logic [CW-1:0] cnt;

    // Reload on request, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/tapseq_planner.sv
// Works out the move for one command: destination, direction and pulse count.
// Assumes the tracked position is already in range. A destination above the top
// tap is clamped, and a homing request always plans a full-span downward run.
module tapseq_planner #(
    parameter int unsigned TAPS  = 32,
    parameter int unsigned POS_W = 5
) (
    input  logic [POS_W-1:0] cur_pos,
    input  logic [POS_W-1:0] target,
    input  logic             home,
    output logic             up,
    output logic [POS_W-1:0] count,
    output logic [POS_W-1:0] dest
);

    localparam logic [POS_W-1:0] TOP = POS_W'(TAPS - 1);

    // Direction and distance between the tracked and the requested tap.
    always_comb begin
        if (home) begin
            dest  = '0;
            up    = 1'b0;
            count = TOP;
        end else begin
            dest  = (target > TOP) ? TOP : target;
            up    = (dest > cur_pos);
            count = up ? (dest - cur_pos) : (cur_pos - dest);
        end
    end

endmodule

// File: rtl/tapseq_tracker.sv
// Keeps the assumed wiper position, one step per falling step edge.
// Saturates at both ends, as the physical wiper does.
module tapseq_tracker #(
    parameter int unsigned TAPS  = 32,
    parameter int unsigned POS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_evt,
    input  logic             up,
    output logic [POS_W-1:0] pos
);

    localparam logic [POS_W-1:0] TOP = POS_W'(TAPS - 1);

    // Saturating up/down position register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (step_evt) begin
            if (up && pos != TOP) begin
                pos <= pos + POS_W'(1);
            end else if (!up && pos != '0) begin
                pos <= pos - POS_W'(1);
            end
        end
    end

endmodule

// File: rtl/tapseq_sequencer.sv
// Host-side sequencer for a three-wire stepped potentiometer.
// Takes one command at a time, plans the move, plays out the step pulses under
// the minimum timing given in ns, and releases the part with a store or a discard.
// Assumes the part's wiper equals the tracked position, which holds after reset
// only once a homing command has run.
module tapseq_sequencer
    import tapseq_pkg::*;
#(
    parameter int unsigned TAPS            = 32,
    parameter int unsigned CLK_HZ          = 50_000_000,
    parameter int unsigned T_SEL_SETUP_NS  = 100,
    parameter int unsigned T_DIR_SETUP_NS  = 2_900,
    parameter int unsigned T_DIR_HOLD_NS   = 100,
    parameter int unsigned T_STEP_LOW_NS   = 1_000,
    parameter int unsigned T_STEP_HIGH_NS  = 1_000,
    parameter int unsigned T_STEP_PER_NS   = 4_000,
    parameter int unsigned T_SETTLE_NS     = 1_000,
    parameter int unsigned T_STORE_REC_NS  = 10_000_000,
    parameter int unsigned T_DISC_REC_NS   = 100,
    localparam int unsigned POS_W          = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [POS_W-1:0] cmd_target,
    input  logic             cmd_store,
    input  logic             cmd_init,
    output logic             done,
    output logic             sel_n,
    output logic             step_n,
    output logic             dir_up,
    output logic [POS_W-1:0] pos_out
);

    // Minimum times in clock cycles.
    localparam int unsigned C_SEL   = cycles_for(T_SEL_SETUP_NS, CLK_HZ);
    localparam int unsigned C_DSU   = cycles_for(T_DIR_SETUP_NS, CLK_HZ);
    localparam int unsigned C_DHOLD = cycles_for(T_DIR_HOLD_NS, CLK_HZ);
    localparam int unsigned C_LOW   = cycles_for(T_STEP_LOW_NS, CLK_HZ);
    localparam int unsigned C_HIGH  = cycles_for(T_STEP_HIGH_NS, CLK_HZ);
    localparam int unsigned C_PER   = cycles_for(T_STEP_PER_NS, CLK_HZ);
    localparam int unsigned C_FIN   = cycles_for(T_SETTLE_NS, CLK_HZ);
    localparam int unsigned C_STORE = cycles_for(T_STORE_REC_NS, CLK_HZ);
    localparam int unsigned C_DISC  = cycles_for(T_DISC_REC_NS, CLK_HZ);

    // State durations built from the minimums.
    localparam int unsigned D_SETUP   = larger(C_SEL, C_DSU);
    localparam int unsigned D_LOW     = C_LOW;
    localparam int unsigned D_LOWLAST = larger(C_LOW, C_FIN);
    localparam int unsigned D_HIGH    = larger(C_HIGH, (C_PER > C_LOW) ? (C_PER - C_LOW) : 1);
    localparam int unsigned D_FIN     = C_FIN;
    localparam int unsigned D_STORE   = C_STORE;
    localparam int unsigned D_DISC    = C_DISC;
    localparam int unsigned D_RECOV   = C_DHOLD;
    localparam int unsigned D_MAX     = larger(larger(larger(D_SETUP, D_LOWLAST), larger(D_HIGH, D_FIN)),
                                               larger(larger(D_STORE, D_DISC), larger(D_RECOV, D_LOW)));
    localparam int unsigned CW        = $clog2(D_MAX + 1);

    localparam logic [CW-1:0] L_SETUP   = CW'(D_SETUP - 1);
    localparam logic [CW-1:0] L_LOW     = CW'(D_LOW - 1);
    localparam logic [CW-1:0] L_LOWLAST = CW'(D_LOWLAST - 1);
    localparam logic [CW-1:0] L_HIGH    = CW'(D_HIGH - 1);
    localparam logic [CW-1:0] L_FIN     = CW'(D_FIN - 1);
    localparam logic [CW-1:0] L_STORE   = CW'(D_STORE - 1);
    localparam logic [CW-1:0] L_DISC    = CW'(D_DISC - 1);
    localparam logic [CW-1:0] L_RECOV   = CW'(D_RECOV - 1);

    seq_state_t       state, nxt;
    logic             tmr_load, tmr_zero, step_evt, accept;
    logic [CW-1:0]    tmr_val;
    logic [POS_W-1:0] remain;
    logic             store_q, up_q;
    logic             plan_up;
    logic [POS_W-1:0] plan_count, plan_dest;
    logic             sel_n_q, step_n_q, done_q;

    tapseq_planner #(.TAPS(TAPS), .POS_W(POS_W)) u_plan (
        .cur_pos (pos_out),
        .target  (cmd_target),
        .home    (cmd_init),
        .up      (plan_up),
        .count   (plan_count),
        .dest    (plan_dest)
    );

    tapseq_tracker #(.TAPS(TAPS), .POS_W(POS_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_evt (step_evt),
        .up       (up_q),
        .pos      (pos_out)
    );

    tapseq_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // Step into the next pulse, choosing the longer low time for a discarding last move.
    function automatic logic [CW-1:0] low_len(input logic [POS_W-1:0] left, input logic keep);
        return (left == POS_W'(1) && !keep) ? L_LOWLAST : L_LOW;
    endfunction

    // Next-state, timer-load and step-event decode.
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        step_evt = 1'b0;
        accept   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (plan_count == '0 && !cmd_store) begin
                        nxt     = ST_RECOV;
                        tmr_val = L_RECOV;
                    end else begin
                        nxt     = ST_SETUP;
                        tmr_val = L_SETUP;
                    end
                end
            end
            ST_SETUP, ST_HIGH: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (remain != '0) begin
                        nxt      = ST_LOW;
                        step_evt = 1'b1;
                        tmr_val  = low_len(remain, store_q);
                    end else begin
                        nxt     = ST_FINAL;
                        tmr_val = L_FIN;
                    end
                end
            end
            ST_LOW: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (remain == '0 && !store_q) begin
                        nxt     = ST_DESEL;
                        tmr_val = L_DISC;
                    end else begin
                        nxt     = ST_HIGH;
                        tmr_val = L_HIGH;
                    end
                end
            end
            ST_FINAL: begin
                if (tmr_zero) begin
                    nxt      = ST_DESEL;
                    tmr_load = 1'b1;
                    tmr_val  = L_STORE;
                end
            end
            ST_DESEL: begin
                if (tmr_zero) begin
                    if (store_q) begin
                        nxt = ST_IDLE;
                    end else begin
                        nxt      = ST_RECOV;
                        tmr_load = 1'b1;
                        tmr_val  = L_RECOV;
                    end
                end
            end
            ST_RECOV: begin
                if (tmr_zero) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State, command latches and remaining-move count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            remain  <= '0;
            store_q <= 1'b0;
            up_q    <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) begin
                store_q <= cmd_store;
                remain  <= plan_count;
                if (plan_count != '0) up_q <= plan_up;
            end else if (step_evt) begin
                remain <= remain - POS_W'(1);
            end
        end
    end

    // Registered line drivers and completion pulse, decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_n_q  <= 1'b1;
            step_n_q <= 1'b1;
            done_q   <= 1'b0;
        end else begin
            sel_n_q  <= !(nxt == ST_SETUP || nxt == ST_LOW || nxt == ST_HIGH || nxt == ST_FINAL);
            step_n_q <= !(nxt == ST_LOW || (nxt == ST_DESEL && !store_q));
            done_q   <= (nxt == ST_IDLE) && (state != ST_IDLE);
        end
    end

    assign cmd_ready = (state == ST_IDLE);
    assign sel_n     = sel_n_q;
    assign step_n    = step_n_q;
    assign dir_up    = up_q;
    assign done      = done_q;

    // plan_dest is implied by the step count; keep it visible for review.
    logic unused_dest;
    assign unused_dest = ^plan_dest;

endmodule

// File: rtl/tapseq_sequencer_chk.sv
// Temporal checks on the sequencer's ports, attached by bind.
module tapseq_sequencer_chk #(
    parameter int unsigned POS_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             done,
    input logic             sel_n,
    input logic             step_n,
    input logic             dir_up,
    input logic [POS_W-1:0] pos_out
);

    // R1: an idle sequencer leaves the part deselected
    assert_idle_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> sel_n);

    // R2: a step edge only happens while the part is selected
    assert_fall_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(step_n) |-> !sel_n);

    // R2: the tracked position moves only with a step edge
    assert_pos_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pos_out) |-> $fell(step_n));

    // R3: direction never changes on a step edge
    assert_dir_steady_at_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(step_n) |-> $stable(dir_up));

    // R5: direction changes only with step already high
    assert_dir_change_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dir_up) |-> (step_n && $past(step_n)));

    // R6: step is steady when select rises
    assert_release_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_n) |-> $stable(step_n));

    // R11: ready drops after acceptance
    assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R11: done lasts a single cycle
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: done coincides with ready
    assert_done_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);

endmodule

bind tapseq_sequencer tapseq_sequencer_chk #(.POS_W(POS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .done      (done),
    .sel_n     (sel_n),
    .step_n    (step_n),
    .dir_up    (dir_up),
    .pos_out   (pos_out)
);

// File: tb/tapseq_sequencer_test.sv
`timescale 1ns/1ps
module tapseq_sequencer_test;

    localparam int CLK_PERIOD = 1000;          // 1 MHz
    localparam longint TB_HZ  = 1_000_000;
    localparam int STORE_NS   = 10_000;        // shortened store recovery

    // Independent ns-to-cycle conversion, R12.
    function automatic int cyc(input longint ns);
        longint c;
        c = (ns * TB_HZ + 999_999_999) / 1_000_000_000;
        return (c < 1) ? 1 : int'(c);
    endfunction

    localparam int E_SEL   = cyc(100);
    localparam int E_DSU   = cyc(2900);
    localparam int E_DHOLD = cyc(100);
    localparam int E_LOW   = cyc(1000);
    localparam int E_HIGH  = cyc(1000);
    localparam int E_PER   = cyc(4000);
    localparam int E_FIN   = cyc(1000);
    localparam int E_STORE = cyc(STORE_NS);
    localparam int E_DISC  = cyc(100);

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid, cmd_store, cmd_init;
    logic [4:0] cmd_target;
    logic       cmd_ready, done, sel_n, step_n, dir_up;
    logic [4:0] pos_out;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tapseq_sequencer #(
        .CLK_HZ         (1_000_000),
        .T_STORE_REC_NS (STORE_NS)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_target (cmd_target),
        .cmd_store  (cmd_store),
        .cmd_init   (cmd_init),
        .done       (done),
        .sel_n      (sel_n),
        .step_n     (step_n),
        .dir_up     (dir_up),
        .pos_out    (pos_out)
    );

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Device model and line monitor, sampled on the falling clock edge.
    int  model_pos;
    int  pulses, store_evts, disc_evts, sel_falls, stored_val;
    bit  last_was_store;
    int  age_sel, age_step, age_dir, age_fall;
    logic ps, pt, pd;

    always @(negedge clk) begin
        if (!rst_n) begin
            model_pos = 17;
            age_sel = 100000; age_step = 100000; age_dir = 100000; age_fall = 100000;
            ps = 1'b1; pt = 1'b1; pd = dir_up;
            last_was_store = 1'b0;
            stored_val = -1;
        end else begin
            if (ps && !sel_n) begin
                sel_falls++;
                chk(age_sel >= (last_was_store ? E_STORE : E_DISC),
                    last_was_store ? "R7 store recovery" : "R8 discard recovery",
                    age_sel, last_was_store ? E_STORE : E_DISC);
            end
            if (!ps && sel_n) begin
                chk(age_step >= E_FIN, "R6 step settle before release", age_step, E_FIN);
                if (step_n) begin
                    store_evts++; stored_val = model_pos; last_was_store = 1'b1;
                end else begin
                    disc_evts++; last_was_store = 1'b0;
                end
            end
            if (pt && !step_n) begin
                chk(!sel_n && !ps, "R2 edge while selected", sel_n, 0);
                pulses++;
                if (dir_up) model_pos = (model_pos < 31) ? model_pos + 1 : 31;
                else        model_pos = (model_pos > 0) ? model_pos - 1 : 0;
                chk(age_sel >= E_SEL, "R3 select setup R12", age_sel, E_SEL);
                chk(pd == dir_up && age_dir >= E_DSU, "R3 direction setup R12", age_dir, E_DSU);
                chk(age_step >= E_HIGH, "R4 high time", age_step, E_HIGH);
                chk(age_fall >= E_PER, "R4 step period", age_fall, E_PER);
                age_fall = 0;
            end
            if (!pt && step_n && !ps) begin
                chk(age_step >= E_LOW, "R4 low time", age_step, E_LOW);
            end
            if (pd != dir_up) begin
                chk(pt && step_n && age_step >= E_DHOLD, "R5 direction hold", age_step, E_DHOLD);
            end
            age_sel  = (sel_n != ps) ? 1 : age_sel + 1;
            age_step = (step_n != pt) ? 1 : age_step + 1;
            age_dir  = (dir_up != pd) ? 1 : age_dir + 1;
            age_fall = age_fall + 1;
            ps = sel_n; pt = step_n; pd = dir_up;
        end
    end

    int exp_pos = 0;

    // Issue one command and check its outcome at the ports.
    task automatic run_cmd(input int tgt, input bit st, input bit home);
        int start, n, dest, busy_bad, dones, iter;
        start = exp_pos;
        dest  = home ? 0 : tgt;
        n     = home ? 31 : ((tgt > start) ? tgt - start : start - tgt);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_target = 5'(tgt); cmd_store = st; cmd_init = home;
        while (!cmd_ready) @(negedge clk);
        pulses = 0; store_evts = 0; disc_evts = 0; sel_falls = 0;
        busy_bad = 0; dones = 0; iter = 0;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (1) begin
            if (done) begin dones++; break; end
            if (cmd_ready) busy_bad++;
            iter++;
            if (iter > 5000) break;
            @(negedge clk);
        end
        chk(dones == 1 && busy_bad == 0, "R11 ready low until done", busy_bad, 0);
        chk(pulses == n, home ? "R10 homing edge count" : "R2 edge count", pulses, n);
        chk(int'(pos_out) == dest, home ? "R10 tracked position" : "R2 tracked position",
            int'(pos_out), dest);
        chk(model_pos == dest, home ? "R10 wiper model" : "R2 wiper model", model_pos, dest);
        if (n > 0) chk(dir_up == (dest > start), "R2 direction", dir_up, dest > start);
        if (st) begin
            chk(store_evts == 1 && disc_evts == 0, "R7 store release", store_evts, 1);
            chk(stored_val == dest, "R7 stored value", stored_val, dest);
        end else if (n > 0) begin
            chk(disc_evts == 1 && store_evts == 0, "R8 discard release", disc_evts, 1);
        end else begin
            chk(sel_falls == 0 && disc_evts == 0, "R9 no pin activity", sel_falls, 0);
        end
        if (n == 0) chk(pulses == 0, "R9 no edges", pulses, 0);
        @(negedge clk);
        chk(done == 1'b0, "R11 done one cycle", done, 0);
        exp_pos = dest;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        cmd_valid = 1'b0; cmd_target = '0; cmd_store = 1'b0; cmd_init = 1'b0;
        repeat (5) @(negedge clk);
        // R1: outputs while reset is held
        chk(sel_n && step_n && cmd_ready && !done && pos_out == 0, "R1 reset state", sel_n, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sel_n == 1'b1, "R1 select idle", sel_n, 1);
        chk(step_n == 1'b1, "R1 step idle", step_n, 1);
        chk(cmd_ready == 1'b1 && done == 1'b0, "R1 handshake idle", cmd_ready, 1);
        chk(pos_out == 5'd0, "R1 position", int'(pos_out), 0);

        // R10: homing from an unknown wiper (model starts at 17)
        run_cmd(0, 1'b1, 1'b1);

        // R2..R9: every source/destination pair, both release kinds
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                run_cmd(a, ((a + b) % 4) == 0, 1'b0);
                run_cmd(b, ((a + b) % 3) == 0, 1'b0);
            end
        end

        // R10: homing from the top clamps the tracked position too
        run_cmd(31, 1'b0, 1'b0);
        run_cmd(0, 1'b0, 1'b1);

        summary();
        $finish;
    end

    initial begin
        repeat (195_000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R11 watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

endmodule